// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two eight-bit buses, called side A and side B. Each transfer direction has its own holding register, and each register has its own capture clock. The A-to-B register samples the A bus on a rising edge of its clock. The B-to-A register samples the B bus on a rising edge of a second clock.

An active-low enable and a direction input decide which side, if any, the block drives. For each direction a select input picks what goes out: live data taken straight from the opposite bus, or the word held in that direction's register. Live data reaches the output through combinational logic only, so it has no clock latency.

Each bus is modelled as three separate signals: an input, an output and an output-enable. There are no tri-state pins, so the block can be synthesized and tested as ordinary logic. With enable high, both outputs are off, which is isolation mode. Both registers can still capture data in isolation mode, and also while their side is not driven.

Top module: `xcvr_top`

## Requirements
- R1: On a rising `clk_ab` edge with `rst_n` high, the A-to-B register loads `a_in`. On a rising `clk_ba` edge with `rst_n` high, the B-to-A register loads `b_in`. Each register keeps its value when its own clock does not rise.
- R2: `rst_n` is an active-low reset, sampled synchronously on each register's own clock. After a reset edge on that clock, the register reads back as 0x00 in stored mode.
- R3: `b_oe` is 1 exactly when `en_n`=0 and `dir`=1. `a_oe` is 1 exactly when `en_n`=0 and `dir`=0. The two are never 1 together.
- R4: When `sel_ab`=0, `b_out` equals `a_in` in the same cycle. When `sel_ab`=1, `b_out` equals the A-to-B register.
- R5: When `sel_ba`=0, `a_out` equals `b_in` in the same cycle. When `sel_ba`=1, `a_out` equals the B-to-A register.
- R6: With `en_n`=1 (isolation), both output-enables are 0, and both registers still capture data on their clocks.
- R7: A register captures data even while the side it feeds is not driven. This holds for either register and for both at the same time.
- R8: `b_out` and `a_out` take their values from the R4 and R5 selection whatever `en_n` and `dir` are. Only `a_oe` and `b_oe` depend on `en_n` and `dir`.
- R9: With the parameter `INVERT_OUT`=1, both data outputs carry the bitwise inverse of the value chosen by R4 and R5. The default is 0, which gives true polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Synchronous active-low reset, sampled on each register's clock |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives side B, 0 drives side A |
| sel_ab | input | 1 | 1 sends the stored word to B, 0 sends live A |
| sel_ba | input | 1 | 1 sends the stored word to A, 0 sends live B |
| a_in | input | 8 | Value currently on bus A |
| a_out | output | 8 | Data offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value currently on bus B |
| b_out | output | 8 | Data offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A register that holds a wrong word shows up at the ports as soon as its direction's select is set to stored mode, with no clock in between. The bench reads each register back that way after every capture, including captures made while the block is isolated. A fault in the enable decoding is visible at once on `a_oe` and `b_oe`. The bench therefore steps through all four combinations of `en_n` and `dir`. The live path is checked in the same cycle that its input changes.

// File: rtl/xcvr_pkg.sv
// Package: shared width and data type for the transceiver.
// Assumes both buses have the same width.
package xcvr_pkg;
    localparam int unsigned BUS_W = 8;
    typedef logic [BUS_W-1:0] bus_t;
endpackage

// File: rtl/xcvr_hold_reg.sv
// Holding register for one transfer direction.
// Loads d_in on every rising edge of clk, because the capture clock itself is
// the load strobe. Reset is synchronous and active low.
// Assumes rst_n is stable around the clk edge.
module xcvr_hold_reg
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  bus_t d_in,
    output bus_t q
);
    // Capture the source bus on each rising edge, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d_in;
    end

    // r1: the register follows its source one edge later.
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q == $past(d_in));
    // r2: a reset edge leaves the register at zero.
    p_reset_r2: assert property (@(posedge clk)
        $past(!rst_n) |-> q == '0);
endmodule

// File: rtl/xcvr_out_mux.sv
// Output path for one direction.
// Chooses between the live opposite-bus value and the stored word, then
// inverts the result if INV is set. This path is purely combinational.
module xcvr_out_mux
    import xcvr_pkg::*;
#(
    parameter bit INV = 1'b0
) (
    input  logic sel_stored,
    input  bus_t live,
    input  bus_t stored,
    output bus_t q
);
    bus_t pick;

    // Choose between the live and the stored source.
    always_comb pick = sel_stored ? stored : live;

    // Apply the output polarity chosen at elaboration.
    generate
        if (INV) begin : g_inv
            always_comb q = ~pick;
        end else begin : g_true
            always_comb q = pick;
        end
    endgenerate

    // r4/r5: the output matches the selected source under the chosen polarity.
    always_comb begin
        a_path_r4_r5: assert (q == (INV ? ~(sel_stored ? stored : live)
                                        : (sel_stored ? stored : live)));
    end
endmodule

// File: rtl/xcvr_dir_ctl.sv
// Direction and enable decode.
// Turns the active-low enable and the direction input into one drive enable
// per side. At most one side is ever enabled.
module xcvr_dir_ctl (
    input  logic en_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);
    // Decode which bus the block drives.
    always_comb begin
        b_oe = ~en_n &  dir;
        a_oe = ~en_n & ~dir;
    end

    // r3: the two sides are never driven together.
    always_comb begin
        p_excl_r3: assert (!(a_oe && b_oe));
    end
    // r6: isolation turns both drivers off.
    always_comb begin
        p_iso_r6: assert (!en_n || (!a_oe && !b_oe));
    end
endmodule

// File: rtl/xcvr_top.sv
// Registered bidirectional bus transceiver, top level.
// Contains two independently clocked holding registers, a stored-or-live
// multiplexer per direction, and the drive-enable decode. Each bus is split
// into in, out and output-enable signals; tri-state pins belong to the chip
// pad ring. Assumes the two clocks need no phase relation.
module xcvr_top
    import xcvr_pkg::*;
#(
    parameter bit INVERT_OUT = 1'b0
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic             a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic             b_oe
);
    bus_t reg_ab, reg_ba;

    xcvr_hold_reg u_reg_ab (.clk(clk_ab), .rst_n(rst_n), .d_in(a_in), .q(reg_ab));
    xcvr_hold_reg u_reg_ba (.clk(clk_ba), .rst_n(rst_n), .d_in(b_in), .q(reg_ba));

    xcvr_out_mux #(.INV(INVERT_OUT)) u_mux_b (
        .sel_stored(sel_ab), .live(a_in), .stored(reg_ab), .q(b_out));
    xcvr_out_mux #(.INV(INVERT_OUT)) u_mux_a (
        .sel_stored(sel_ba), .live(b_in), .stored(reg_ba), .q(a_out));

    xcvr_dir_ctl u_ctl (.en_n(en_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe));

    // r7: the A-to-B register captures even while B is not driven.
    p_cap_undriven_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
        ($past(rst_n) && $past(!b_oe)) |-> reg_ab == $past(a_in));
endmodule

// File: tb/xcvr_top_tb_top.sv
// Directed bench for xcvr_top. There is one task per scenario.
module xcvr_top_tb_top;
    localparam time CLK_HALF = 5ns;

    logic clk_ab = 0, clk_ba = 0, rst_n = 0, en_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
    logic [7:0] a_in = 0, b_in = 0;
    logic [7:0] a_out, b_out, ia_out, ib_out;
    logic a_oe, b_oe, ia_oe, ib_oe;
    int total = 0, bad = 0;

    xcvr_top dut_i (.clk_ab, .clk_ba, .rst_n, .en_n, .dir, .sel_ab, .sel_ba,
        .a_in, .a_out, .a_oe, .b_in, .b_out, .b_oe);
    xcvr_top #(.INVERT_OUT(1'b1)) inv_i (.clk_ab, .clk_ba, .rst_n, .en_n, .dir,
        .sel_ab, .sel_ba, .a_in, .a_out(ia_out), .a_oe(ia_oe), .b_in,
        .b_out(ib_out), .b_oe(ib_oe));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One pulse on the selected clock or clocks; returns with the clocks low.
    task automatic pulse(input bit ab, input bit ba);
        #(CLK_HALF);
        clk_ab = ab; clk_ba = ba;
        #(CLK_HALF);
        clk_ab = 0; clk_ba = 0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 0; a_in = 8'h5A; b_in = 8'hA5;
        pulse(1, 1);
        rst_n = 1; sel_ab = 1; sel_ba = 1; #1;
        chk("R2 reg_ab", b_out, 8'h00);
        chk("R2 reg_ba", a_out, 8'h00);
        chk("R6 a_oe", {7'b0, a_oe}, 0);
        chk("R6 b_oe", {7'b0, b_oe}, 0);
    endtask

    task automatic t_decode;
        for (int k = 0; k < 4; k++) begin
            en_n = k[1]; dir = k[0]; #1;
            chk("R3 b_oe", {7'b0, b_oe}, {7'b0, ~k[1] & k[0]});
            chk("R3 a_oe", {7'b0, a_oe}, {7'b0, ~k[1] & ~k[0]});
        end
    endtask

    task automatic t_live;
        sel_ab = 0; sel_ba = 0; en_n = 0; dir = 1;
        a_in = 8'h3C; b_in = 8'hC3; #1;
        chk("R4 live", b_out, 8'h3C);
        chk("R5 live", a_out, 8'hC3);
        a_in = 8'hFF; #1;
        chk("R4 live same cycle", b_out, 8'hFF);
    endtask

    task automatic t_stored;
        sel_ab = 1; sel_ba = 1; a_in = 8'h11; b_in = 8'h22;
        pulse(1, 0);
        a_in = 8'h99; #1;
        chk("R4 stored", b_out, 8'h11);
        chk("R1 ba held", a_out, 8'h00);
        pulse(0, 1);
        b_in = 8'h77; #1;
        chk("R5 stored", a_out, 8'h22);
        chk("R1 ab held", b_out, 8'h11);
    endtask

    task automatic t_isolate;
        en_n = 1; a_in = 8'h6E; b_in = 8'hE6;
        pulse(1, 1);
        #1;
        chk("R6 cap ab", b_out, 8'h6E);
        chk("R6 cap ba", a_out, 8'hE6);
        chk("R8 iso a_oe", {7'b0, a_oe}, 0);
    endtask

    task automatic t_undriven;
        en_n = 0; dir = 0; a_in = 8'h81; b_in = 8'h18;
        pulse(1, 1);
        #1;
        chk("R7 ab while B off", b_out, 8'h81);
        chk("R7 ba while A driven", a_out, 8'h18);
        sel_ab = 0; #1;
        chk("R8 b_out while off", b_out, 8'h81);
    endtask

    task automatic t_invert;
        sel_ab = 0; sel_ba = 1; a_in = 8'h0F; #1;
        chk("R9 inv live", ib_out, 8'hF0);
        chk("R9 inv stored", ia_out, ~8'h18);
        chk("R9 true default", b_out, 8'h0F);
    endtask

    initial begin
        fork
            begin
                t_reset; t_decode; t_live; t_stored; t_isolate; t_undriven; t_invert;
            end
            begin
                #(CLK_HALF * 4000);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule